// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block is the device-side bank of configuration base address registers (BARs) for a PCI function. Each register slot is fixed at elaboration time. It is either a 32-bit memory region, a 64-bit memory region that takes the next slot as its upper half, an I/O region, or unused. Each region has a power-of-two size. System software reads and writes the slots over a narrow configuration port. Writing all ones and reading the value back reveals the region size. Writing a base address places the region in the address map.

The same bank also works as the address decoder for incoming transactions. It compares a transaction address with every programmed region, using the region's size mask. When a region claims the transaction, the bank reports which slot it is. Memory decoding and I/O decoding each have their own enable input. A region cannot claim anything until software has written its base register.

Top module: `bar_bank_top`

## Requirements
- R1: There are NUM_BARS (up to six) 32-bit slots, selected by `cfg_idx`. `cfg_rdata` shows the selected slot combinationally. A write with `cfg_wr_en` takes effect at the clock edge and is visible from the next cycle. An index of NUM_BARS or above reads zero, and a write to it changes no slot.
- R2: Bit 0 of a slot reads 1 for an I/O region and 0 for a memory region. Writes never change it.
- R3: For a memory slot, bits 2:1 read 00 for a 32-bit region and 10 for a 64-bit region, and bit 3 reads 0. For an I/O slot, bit 1 reads 0. None of these bits can be written.
- R4: Address bits below the region size (2^S bytes) always read zero. Writing all ones to a slot returns ~(2^S−1) combined with its type bits.
- R5: A 64-bit region holds bits 63:32 of its base in the following slot. If S > 32, the low S−32 bits of that upper slot read zero. Otherwise the upper slot is fully writable. If S ≥ 32, the lower slot of the pair has no writable bits.
- R6: After reset, every writable bit is zero and every slot is marked unprogrammed. A slot becomes programmed on its first configuration write. A region claims nothing until its slot is programmed, and for a 64-bit region both slots of the pair must be programmed.
- R7: A memory transaction (`txn_valid`=1, `txn_is_io`=0) hits a memory region when `mem_en`=1 and the 64-bit address equals the base under the size mask. A 32-bit region therefore also requires address bits 63:32 to be zero. Without `txn_valid` there is never a hit.
- R8: An I/O transaction (`txn_is_io`=1) hits an I/O region under the same masked compare when `io_en`=1. Address bits 63:32 must be zero.
- R9: With `mem_en`=0, no memory region hits. With `io_en`=0, no I/O region hits. A transaction of one space never hits a region of the other space.
- R10: When regions overlap, the region with the lowest slot index wins. `hit_idx` gives that region's lower slot index, and it is zero whenever `hit` is 0.
- R11: The decoder is combinational on the current slot contents. A transaction in the same cycle as a configuration write is decoded with the old base, and the new base takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (3) | Slot index for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Contents of the selected slot |
| mem_en | input | 1 | Enables memory-space decoding |
| io_en | input | 1 | Enables I/O-space decoding |
| txn_valid | input | 1 | An incoming transaction is present |
| txn_is_io | input | 1 | 1 for an I/O transaction, 0 for a memory transaction |
| txn_addr | input | 64 | Transaction address |
| hit | output | 1 | Some region claims the transaction |
| hit_idx | output | IDX_W (3) | Lower slot index of the claiming region |

## Verification
A configuration write and an address decode can happen in the same cycle. The question is which base the decoder uses in that cycle. The bench drives a write that moves a region while a transaction, in the same cycle, targets either the new base or the old one. A behavioural model updates its registers only after the clock edge, and it is compared with the design on every cycle. The comparison therefore requires a hit on the old base during the write cycle and a hit on the new base only in the cycle after.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

   localparam int MAX_BARS = 6;
   localparam int REG_W    = 32;
   localparam int TXN_AW   = 64;
   localparam int SIZE_FW  = 6;

   typedef enum logic [1:0] {
      BK_NONE  = 2'd0,
      BK_MEM32 = 2'd1,
      BK_MEM64 = 2'd2,
      BK_IO    = 2'd3
   } bar_kind_e;

   // slot kind from the packed per-slot kind vector
   function automatic bar_kind_e kind_of(input logic [2*MAX_BARS-1:0] kinds, input int idx);
      return bar_kind_e'(kinds[2*idx +: 2]);
   endfunction

   // log2 of region size from the packed per-slot size vector
   function automatic int size_of(input logic [SIZE_FW*MAX_BARS-1:0] sizes, input int idx);
      return int'(sizes[SIZE_FW*idx +: SIZE_FW]);
   endfunction

   // 64-bit mask keeping address bits at and above the region size
   function automatic logic [TXN_AW-1:0] region_mask(input int size_log2);
      return ~((64'd1 << size_log2) - 64'd1);
   endfunction

endpackage

// File: rtl/bar_reg_slot.sv
module bar_reg_slot
   import bar_bank_pkg::*;
#(
   parameter bar_kind_e KIND           = BK_NONE,
   parameter int        SIZE_LOG2      = 12,
   parameter bit        IS_UPPER       = 1'b0,
   parameter int        PAIR_SIZE_LOG2 = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rd_val,
   output logic [REG_W-1:0] base_out,
   output logic             programmed
);

   localparam logic [TXN_AW-1:0] RMASK = region_mask(IS_UPPER ? PAIR_SIZE_LOG2 : SIZE_LOG2);

   localparam logic [REG_W-1:0] WMASK =
      IS_UPPER          ? RMASK[63:32] :
      (KIND == BK_NONE) ? 32'h0 :
      (KIND == BK_IO)   ? (RMASK[31:0] & ~32'h3) :
                          (RMASK[31:0] & ~32'hF);

   localparam logic [REG_W-1:0] TYPE_BITS =
      IS_UPPER           ? 32'h0 :
      (KIND == BK_IO)    ? 32'h1 :
      (KIND == BK_MEM64) ? 32'h4 :
                           32'h0;

   logic [REG_W-1:0] base_q;
   logic             prog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         prog_q <= 1'b0;
      end else if (wr_en) begin
         base_q <= wdata & WMASK;
         prog_q <= 1'b1;
      end
   end

   assign rd_val     = base_q | TYPE_BITS;
   assign base_out   = base_q;
   assign programmed = prog_q;

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_val == (($past(wdata) & WMASK) | TYPE_BITS))); // R4
   AST_PROG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> programmed); // R6
   AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      programmed |=> programmed); // R6
   AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_val & ~WMASK) == $past(rd_val & ~WMASK))); // R2

endmodule

// File: rtl/bar_hit_match.sv
module bar_hit_match
   import bar_bank_pkg::*;
#(
   parameter bit IS_IO     = 1'b0,
   parameter int SIZE_LOG2 = 12
) (
   input  logic              ready,
   input  logic              space_en,
   input  logic [TXN_AW-1:0] base,
   input  logic              txn_valid,
   input  logic              txn_is_io,
   input  logic [TXN_AW-1:0] txn_addr,
   output logic              match
);

   localparam logic [TXN_AW-1:0] MASK = region_mask(SIZE_LOG2);

   logic space_ok;
   logic addr_ok;

   assign space_ok = space_en && (txn_is_io == IS_IO);
   assign addr_ok  = ((txn_addr & MASK) == (base & MASK));
   assign match    = txn_valid && ready && space_ok && addr_ok;

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select #(
   parameter int NUM   = 6,
   parameter int IDX_W = 3
) (
   input  logic [NUM-1:0]   match,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);

   always_comb begin
      hit     = |match;
      hit_idx = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/bar_bank_top.sv
module bar_bank_top
   import bar_bank_pkg::*;
#(
   parameter int NUM_BARS = 6,
   parameter logic [2*MAX_BARS-1:0] BAR_KINDS =
      {BK_NONE, BK_MEM32, BK_NONE, BK_MEM64, BK_IO, BK_MEM32},
   parameter logic [SIZE_FW*MAX_BARS-1:0] BAR_SIZES =
      {6'd0, 6'd16, 6'd0, 6'd20, 6'd5, 6'd12},
   localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              mem_en,
   input  logic              io_en,
   input  logic              txn_valid,
   input  logic              txn_is_io,
   input  logic [TXN_AW-1:0] txn_addr,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx
);

   localparam int SLOTS_P2 = 1 << IDX_W;

   logic [REG_W-1:0]    slot_rd   [NUM_BARS];
   logic [REG_W-1:0]    slot_base [NUM_BARS];
   logic [NUM_BARS-1:0] slot_prog;
   logic [NUM_BARS-1:0] match_vec;
   logic [SLOTS_P2-1:0] match_pad;

   if (NUM_BARS < 1 || NUM_BARS > MAX_BARS) begin : g_bad_count
      $error("bar_bank_top: NUM_BARS out of range");
   end

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
      localparam bar_kind_e KIND_I  = kind_of(BAR_KINDS, i);
      localparam int        SIZE_I  = size_of(BAR_SIZES, i);
      localparam int        PREV_I  = (i > 0) ? i - 1 : 0;
      localparam bit        UPPER_I = (i > 0) && (kind_of(BAR_KINDS, PREV_I) == BK_MEM64);
      localparam int        PAIR_SZ = UPPER_I ? size_of(BAR_SIZES, PREV_I) : 0;

      // elaboration-time parameter checks
      if (UPPER_I && KIND_I != BK_NONE) begin : g_bad_upper
         $error("bar_bank_top: slot after a 64-bit region must be BK_NONE");
      end
      if (KIND_I == BK_IO && (SIZE_I < 2 || SIZE_I > 31)) begin : g_bad_io
         $error("bar_bank_top: I/O region size out of range");
      end
      if (KIND_I == BK_MEM32 && (SIZE_I < 4 || SIZE_I > 31)) begin : g_bad_m32
         $error("bar_bank_top: 32-bit memory region size out of range");
      end
      if (KIND_I == BK_MEM64 && (SIZE_I < 4 || SIZE_I > 63 || i == NUM_BARS - 1)) begin : g_bad_m64
         $error("bar_bank_top: 64-bit memory region size or position invalid");
      end

      bar_reg_slot #(
         .KIND           (KIND_I),
         .SIZE_LOG2      (SIZE_I),
         .IS_UPPER       (UPPER_I),
         .PAIR_SIZE_LOG2 (PAIR_SZ)
      ) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (cfg_wr_en && (cfg_idx == IDX_W'(i))),
         .wdata      (cfg_wdata),
         .rd_val     (slot_rd[i]),
         .base_out   (slot_base[i]),
         .programmed (slot_prog[i])
      );
   end

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_region
      localparam bar_kind_e KIND_I = kind_of(BAR_KINDS, i);
      localparam int        SIZE_I = size_of(BAR_SIZES, i);

      if (KIND_I == BK_NONE) begin : g_idle
         logic unused_slot_bits;
         assign unused_slot_bits = ^{slot_base[i], slot_prog[i]};
         assign match_vec[i]     = 1'b0;
      end else begin : g_live
         logic [TXN_AW-1:0] base_i;
         logic              ready_i;

         if (KIND_I == BK_MEM64) begin : g_wide
            assign base_i  = {slot_base[i+1], slot_base[i]};
            assign ready_i = slot_prog[i] & slot_prog[i+1];
         end else begin : g_narrow
            assign base_i  = {32'h0, slot_base[i]};
            assign ready_i = slot_prog[i];
         end

         bar_hit_match #(
            .IS_IO     (KIND_I == BK_IO),
            .SIZE_LOG2 (SIZE_I)
         ) u_match (
            .ready     (ready_i),
            .space_en  ((KIND_I == BK_IO) ? io_en : mem_en),
            .base      (base_i),
            .txn_valid (txn_valid),
            .txn_is_io (txn_is_io),
            .txn_addr  (txn_addr),
            .match     (match_vec[i])
         );
      end
   end

   bar_hit_select #(
      .NUM   (NUM_BARS),
      .IDX_W (IDX_W)
   ) u_select (
      .match   (match_vec),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_BARS; i++) begin
         if (cfg_idx == IDX_W'(i)) cfg_rdata = slot_rd[i];
      end
   end

   assign match_pad = SLOTS_P2'(match_vec);

   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_idx) >= NUM_BARS) |-> (cfg_rdata == '0)); // R1
   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |-> !hit); // R7
   AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_is_io && !mem_en) |-> !hit); // R9
   AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_is_io && !io_en) |-> !hit); // R9
   AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> match_pad[hit_idx]); // R10
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((match_pad & ~({SLOTS_P2{1'b1}} << hit_idx)) == '0)); // R10
   AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0)); // R10

endmodule

// File: tb/bar_bank_top_tb_top.sv
`timescale 1ns/1ps
module bar_bank_top_tb_top;
   import bar_bank_pkg::*;

   localparam int NB = 6;
   localparam logic [2*MAX_BARS-1:0] TB_KINDS =
      {BK_NONE, BK_MEM64, BK_MEM32, BK_IO, BK_NONE, BK_MEM64};
   localparam logic [SIZE_FW*MAX_BARS-1:0] TB_SIZES =
      {6'd0, 6'd20, 6'd12, 6'd5, 6'd0, 6'd34};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_en = 1'b0;
   logic        io_en = 1'b0;
   logic        txn_valid = 1'b0;
   logic        txn_is_io = 1'b0;
   logic [63:0] txn_addr = '0;
   logic        hit;
   logic [2:0]  hit_idx;

   always #5 clk = ~clk;

   bar_bank_top #(.NUM_BARS(NB), .BAR_KINDS(TB_KINDS), .BAR_SIZES(TB_SIZES)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_en(mem_en), .io_en(io_en),
      .txn_valid(txn_valid), .txn_is_io(txn_is_io), .txn_addr(txn_addr),
      .hit(hit), .hit_idx(hit_idx)
   );

   int    tests = 0;
   int    fails = 0;
   bit    done  = 1'b0;
   string cur_req = "R6";

   // ---------------- reference model ----------------
   logic [31:0] m_reg  [8];
   bit          m_prog [8];

   // slot layout: 0/1 = 64-bit memory 2^34, 2 = I/O 2^5, 3 = 32-bit memory 2^12, 4/5 = 64-bit memory 2^20
   function automatic logic [31:0] m_type(input int i);
      case (i)
         0, 4:    return 32'h4;
         2:       return 32'h1;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] m_wmask(input int i);
      case (i)
         1:       return 32'hFFFF_FFFF << 2;
         2:       return 32'hFFFF_FFFF << 5;
         3:       return 32'hFFFF_FFFF << 12;
         4:       return 32'hFFFF_FFFF << 20;
         5:       return 32'hFFFF_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 8; i++) begin
         m_reg[i]  = m_type(i);
         m_prog[i] = 1'b0;
      end
   endtask

   task automatic m_expect(output logic h, output logic [2:0] idx);
      h = 1'b0;
      idx = '0;
      for (int k = 0; k < 4; k++) begin
         int lo;
         int s;
         bit io;
         bit wide;
         bit rdy;
         logic [63:0] base;
         logic [63:0] msk;
         case (k)
            0:       begin lo = 0; s = 34; io = 1'b0; wide = 1'b1; end
            1:       begin lo = 2; s = 5;  io = 1'b1; wide = 1'b0; end
            2:       begin lo = 3; s = 12; io = 1'b0; wide = 1'b0; end
            default: begin lo = 4; s = 20; io = 1'b0; wide = 1'b1; end
         endcase
         base = wide ? {m_reg[lo+1], m_reg[lo] & ~32'hF}
                     : {32'h0, m_reg[lo] & (io ? ~32'h3 : ~32'hF)};
         rdy  = m_prog[lo] && (!wide || m_prog[lo+1]);
         msk  = ~64'h0 << s;
         if (!h && txn_valid && rdy && (txn_is_io == io) && (io ? io_en : mem_en)
             && ((txn_addr & msk) == base)) begin
            h   = 1'b1;
            idx = 3'(lo);
         end
      end
   endtask

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   initial m_reset();

   // compare every cycle, away from the clock edge; update model after the edge
   initial begin
      forever begin
         logic        eh;
         logic [2:0]  ei;
         logic [31:0] erd;
         @(negedge clk);
         #4;
         if (!rst_n) m_reset();
         erd = (cfg_idx < 3'd6) ? m_reg[cfg_idx] : 32'h0;
         m_expect(eh, ei);
         check("cfg_rdata", 64'(cfg_rdata), 64'(erd));
         check("hit", 64'(hit), 64'(eh));
         check("hit_idx", 64'(hit_idx), 64'(ei));
         @(posedge clk);
         #1;
         if (!rst_n) m_reset();
         else if (cfg_wr_en && cfg_idx < 3'd6) begin
            m_reg[cfg_idx]  = (cfg_wdata & m_wmask(int'(cfg_idx))) | m_type(int'(cfg_idx));
            m_prog[cfg_idx] = 1'b1;
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input bit we, input int idx, input logic [31:0] wd,
                       input bit tv, input bit tio, input logic [63:0] ta);
      @(negedge clk);
      cfg_wr_en = we;
      cfg_idx   = 3'(idx);
      cfg_wdata = wd;
      txn_valid = tv;
      txn_is_io = tio;
      txn_addr  = ta;
   endtask

   task automatic wr(input int idx, input logic [31:0] wd);
      step(1'b1, idx, wd, 1'b0, 1'b0, 64'h0);
   endtask

   task automatic rd(input int idx);
      step(1'b0, idx, 32'h0, 1'b0, 1'b0, 64'h0);
   endtask

   task automatic mem(input logic [63:0] a);
      step(1'b0, 0, 32'h0, 1'b1, 1'b0, a);
   endtask

   task automatic iot(input logic [63:0] a);
      step(1'b0, 0, 32'h0, 1'b1, 1'b1, a);
   endtask

   task automatic program_map();
      wr(0, 32'h0);
      wr(1, 32'h4);
      wr(2, 32'h1000);
      wr(3, 32'h8000);
      wr(4, 32'h0010_0000);
      wr(5, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // ---------------- test sequence ----------------
   initial begin
      cur_req = "R6";
      for (int i = 0; i < 3; i++) rd(i);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) rd(i);
      mem_en = 1'b1;
      io_en  = 1'b1;
      mem(64'h0);
      iot(64'h0);
      mem(64'h10);

      cur_req = "R4";
      for (int i = 0; i < 6; i++) begin
         wr(i, 32'hFFFF_FFFF);
         rd(i);
      end
      cur_req = "R1";
      wr(6, 32'hFFFF_FFFF);
      rd(6);
      wr(7, 32'hFFFF_FFFF);
      rd(7);
      for (int i = 0; i < 6; i++) rd(i);

      cur_req = "R2";
      for (int i = 0; i < 6; i++) begin
         wr(i, 32'h0);
         rd(i);
      end
      cur_req = "R3";
      wr(0, 32'h0000_000E); rd(0);
      wr(3, 32'h0000_000F); rd(3);
      wr(2, 32'h0000_0003); rd(2);

      cur_req = "R5";
      wr(1, 32'h1234_5677); rd(1);
      wr(5, 32'hDEAD_BEEF); rd(5);
      wr(0, 32'hFFFF_FFF0); rd(0);

      program_map();
      cur_req = "R7";
      mem(64'h4_0000_0000);
      mem(64'h7_FFFF_FFFF);
      mem(64'h8_0000_0000);
      mem(64'h3_FFFF_FFFF);
      mem(64'h8000);
      mem(64'h8FFF);
      mem(64'h9000);
      mem(64'h10_0000);
      mem(64'h1F_FFFF);
      mem(64'h1_0000_8000);
      mem(64'h1_0010_0000);
      step(1'b0, 0, 32'h0, 1'b0, 1'b0, 64'h8000);

      cur_req = "R8";
      iot(64'h1000);
      iot(64'h101F);
      iot(64'h1020);
      iot(64'h1_0000_1000);
      iot(64'h0FFF);

      cur_req = "R9";
      iot(64'h8000);
      mem(64'h1000);
      mem_en = 1'b0;
      mem(64'h8000);
      iot(64'h1000);
      io_en = 1'b0;
      iot(64'h1000);
      mem_en = 1'b1;
      mem(64'h8000);
      io_en = 1'b1;
      iot(64'h1004);

      cur_req = "R10";
      wr(4, 32'h0);
      mem(64'h8000);
      mem(64'h9000);
      mem(64'h0);
      wr(5, 32'h4);
      wr(4, 32'h0010_0000);
      mem(64'h4_0010_0000);
      mem(64'h4_0000_0000);
      mem(64'h5_0000_0000);

      cur_req = "R11";
      step(1'b1, 3, 32'h0002_0000, 1'b1, 1'b0, 64'h0002_0000);
      mem(64'h0002_0000);
      step(1'b1, 3, 32'h0003_0000, 1'b1, 1'b0, 64'h0002_0000);
      mem(64'h0002_0000);
      step(1'b1, 2, 32'h0000_2000, 1'b1, 1'b1, 64'h1000);
      iot(64'h2000);

      cur_req = "R6";
      @(negedge clk);
      rst_n = 1'b0;
      cfg_wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      mem(64'h0);
      iot(64'h0);
      wr(0, 32'h0);
      mem(64'h0);
      wr(1, 32'h0);
      mem(64'h0);
      mem(64'h1_0000_0000);

      cur_req = "R7";
      program_map();
      for (int n = 0; n < 400; n++) begin
         logic [63:0] a;
         int          pick;
         pick = $urandom_range(0, 5);
         case (pick)
            0:       a = 64'h4_0000_0000;
            1:       a = 64'h1000;
            2:       a = 64'h8000;
            3:       a = 64'h10_0000;
            4:       a = 64'h4_0010_0000;
            default: a = {32'($urandom_range(0, 7)), 32'($urandom)};
         endcase
         a = a + 64'($urandom_range(0, 32'h1FFF));
         mem_en = ($urandom_range(0, 7) != 0);
         io_en  = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 11) == 0)
            step(1'b1, $urandom_range(0, 7), ($urandom_range(0, 1) != 0) ? $urandom : 32'h0010_0000,
                 $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, a);
         else
            step(1'b0, $urandom_range(0, 7), 32'h0,
                 $urandom_range(0, 5) != 0, $urandom_range(0, 2) == 0, a);
      end

      rd(0);
      @(negedge clk);
      finish_run();
   end

endmodule